// File: doc/BRIEF.md
# Spinning Reel with Glyph Display

This block is a single reel of a multi-reel game. It keeps a two-bit position that steps forward once per clock while the game is spinning. The position drives a seven-segment glyph through combinational logic. Each reel also keeps a sticky "halted" flag. A game controller, which lies outside this block, broadcasts a two-bit phase code. Each reel has its own halt button.

The phase code is read as follows:

| Code | Phase |
|------|-------|
| 0 | idle |
| 1 | initialise |
| 2 | spin |
| 3 | payout |

In the initialise phase the position returns to zero and the flag clears. In the spin phase a press of the button freezes the reel. The flag then reports that the reel has halted, so the controller can move on once every reel is frozen. In the idle and payout phases the reel keeps its state, so the controller can judge the final positions.

The four positions display, in order, a capital P, a lower-case r, a capital J and the digit 1. The sequence then wraps.

Top module: `reel_unit`

## Requirements
- R1: While the synchronous active-high `rst` is 1 at a rising edge, `reelVal` becomes 0 and `stopped` becomes 0 after that edge.
- R2: An edge with `gameState` = 1 sets `reelVal` to 0 and clears `stopped`, whatever the button does.
- R3: An edge with `gameState` = 2, `stopBtn` = 0 and `stopped` = 0 adds one to `reelVal`, wrapping from 3 to 0.
- R4: An edge with `gameState` = 2 and `stopBtn` = 1 sets `stopped`, and `reelVal` keeps its value on that edge.
- R5: While `stopped` is 1 in the spin phase, `reelVal` keeps its value and `stopped` stays 1.
- R6: Edges with `gameState` = 0 or 3 leave both `reelVal` and `stopped` unchanged, whatever the button does.
- R7: `segOut` bit 0 is segment a and bit 6 is segment g, and the segments are active-high. The pattern depends only on `reelVal`:

| `reelVal` | Glyph | Segments lit | `segOut` |
|-----------|-------|--------------|----------|
| 0 | P | a,b,e,f,g | 7'b1110011 |
| 1 | r | e,g | 7'b1010000 |
| 2 | J | b,c,d,e | 7'b0011110 |
| 3 | 1 | b,c | 7'b0000110 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| gameState | input | 2 | Phase code from the game controller |
| stopBtn | input | 1 | Halt request for this reel |
| reelVal | output | 2 | Current reel position |
| segOut | output | 7 | Segment drive, bit 0 = a … bit 6 = g |
| stopped | output | 1 | Sticky halted flag |

## Verification
The properties assume that `gameState` and `stopBtn` are settled and free of X at every rising edge. They also assume that the button is already debounced and synchronised, since this block does no filtering.

The stimulus changes inputs only at falling edges and draws phase codes from the full 0..3 range. The spin phase is given extra weight so that wraps happen often. The button is pressed sparsely, so that long spins and early halts both occur.

Directed sequences cover the following cases:
- a wrap from 3 to 0;
- a press in every phase other than spin;
- a reset while the reel is halted.

// File: rtl/reel_pkg.sv
package reel_pkg;
  localparam int POS_W = 2;
  localparam int SEG_N = 7;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE   = 2'd0,
    PH_INIT   = 2'd1,
    PH_SPIN   = 2'd2,
    PH_PAYOUT = 2'd3
  } phase_e;

  typedef struct packed {
    logic clear;
    logic advance;
    logic halt;
  } reel_strobe_t;

  function automatic logic [SEG_N-1:0] glyphOf(input logic [POS_W-1:0] pos);
    logic [SEG_N-1:0] s;
    case (pos)
      2'd0:    s = 7'b1110011;
      2'd1:    s = 7'b1010000;
      2'd2:    s = 7'b0011110;
      default: s = 7'b0000110;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/reel_ctrl.sv
module reel_ctrl
  import reel_pkg::*;
(
  input  logic [PHASE_W-1:0] gameState,
  input  logic               stopBtn,
  input  logic               haltFlag,
  output reel_strobe_t       strobe
);
  phase_e phase;

  always_comb begin
    phase = phase_e'(gameState);
    strobe = '0;
    unique case (phase)
      PH_INIT: strobe.clear = 1'b1;
      PH_SPIN: begin
        strobe.halt    = stopBtn;
        strobe.advance = !stopBtn && !haltFlag;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/reel_datapath.sv
module reel_datapath
  import reel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  reel_strobe_t     strobe,
  output logic [POS_W-1:0] posQ,
  output logic             haltFlag,
  output logic [SEG_N-1:0] segs
);
  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      posQ     <= '0;
      haltFlag <= 1'b0;
    end else begin
      if (strobe.advance) posQ <= posQ + 1'b1;
      if (strobe.halt)    haltFlag <= 1'b1;
    end
  end

  always_comb segs = glyphOf(posQ);
endmodule

// File: rtl/reel_unit.sv
module reel_unit
  import reel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] gameState,
  input  logic               stopBtn,
  output logic [POS_W-1:0]   reelVal,
  output logic [SEG_N-1:0]   segOut,
  output logic               stopped
);
  reel_strobe_t strobe;
  logic haltFlag;

  reel_ctrl u_ctrl (
    .gameState(gameState),
    .stopBtn(stopBtn),
    .haltFlag(haltFlag),
    .strobe(strobe)
  );

  reel_datapath u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .posQ(reelVal),
    .haltFlag(haltFlag),
    .segs(segOut)
  );

  assign stopped = haltFlag;
endmodule

// File: rtl/reel_unit_chk.sv
module reel_unit_chk
  import reel_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] gameState,
  input logic               stopBtn,
  input logic [POS_W-1:0]   reelVal,
  input logic [SEG_N-1:0]   segOut,
  input logic               stopped
);
  assert_init_clears_R2: assert property (@(posedge clk) disable iff (rst)
    gameState == 2'd1 |=> (reelVal == '0) && !stopped);

  assert_spin_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (gameState == 2'd2 && !stopBtn && !stopped) |=> reelVal == POS_W'($past(reelVal) + 1'b1));

  assert_press_latches_R4: assert property (@(posedge clk) disable iff (rst)
    (gameState == 2'd2 && stopBtn) |=> stopped && $stable(reelVal));

  assert_halted_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (gameState == 2'd2 && stopped) |=> stopped && $stable(reelVal));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (gameState == 2'd0 || gameState == 2'd3) |=> $stable(reelVal) && $stable(stopped));

  assert_glyph_lit_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(segOut) >= 2 && !segOut[SEG_N-1] == (reelVal[1]));
endmodule

bind reel_unit reel_unit_chk u_chk (.*);

// File: tb/reel_unit_bench.sv
module reel_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] gameState = 2'd0;
  logic stopBtn = 1'b0;
  logic [1:0] reelVal;
  logic [6:0] segOut;
  logic stopped;

  int checks = 0;
  int fails = 0;
  logic [1:0] refPos = 2'd0;
  logic refHalt = 1'b0;

  always #4 clk = ~clk;

  reel_unit u_reel_unit (
    .clk(clk), .rst(rst), .gameState(gameState), .stopBtn(stopBtn),
    .reelVal(reelVal), .segOut(segOut), .stopped(stopped)
  );

  function automatic logic [6:0] expSeg(input logic [1:0] v);
    case (v)
      2'd0: return 7'b1110011;
      2'd1: return 7'b1010000;
      2'd2: return 7'b0011110;
      default: return 7'b0000110;
    endcase
  endfunction

  function automatic string tagFor(input logic r, input logic [1:0] st, input logic b, input logic h);
    if (r) return "R1";
    if (st == 2'd1) return "R2";
    if (st == 2'd2 && b) return "R4";
    if (st == 2'd2 && h) return "R5";
    if (st == 2'd2) return "R3";
    return "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] st, input logic b);
    string tag;
    tag = tagFor(r, st, b, refHalt);
    rst = r; gameState = st; stopBtn = b;
    @(posedge clk);
    if (r || st == 2'd1) begin
      refPos = 2'd0; refHalt = 1'b0;
    end else if (st == 2'd2) begin
      if (b) refHalt = 1'b1;
      else if (!refHalt) refPos = refPos + 2'd1;
    end
    @(negedge clk);
    check(tag, reelVal, refPos);
    check(tag, stopped, refHalt);
    check("R7", segOut, expSeg(refPos));
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5107));
    @(negedge clk);
    step(1'b1, 2'd2, 1'b0);   // R1 reset state
    step(1'b0, 2'd1, 1'b0);   // R2
    for (int i = 0; i < 6; i++) step(1'b0, 2'd2, 1'b0); // R3 wrap 3->0
    step(1'b0, 2'd0, 1'b1);   // R6 press in idle ignored
    step(1'b0, 2'd3, 1'b1);   // R6 press in payout ignored
    step(1'b0, 2'd2, 1'b1);   // R4
    step(1'b0, 2'd2, 1'b0);   // R5
    step(1'b0, 2'd3, 1'b0);   // R6
    step(1'b1, 2'd0, 1'b0);   // R1 reset while halted
    step(1'b0, 2'd1, 1'b1);   // R2 press during init
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] st;
      int pick;
      pick = $urandom_range(0, 9);
      st = (pick < 5) ? 2'd2 : 2'($urandom_range(0, 3));
      step(($urandom_range(0, 99) == 0), st, ($urandom_range(0, 7) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule